// File: doc/BRIEF.md
# Three-Phase Voltage Sag Detector

This block watches a stream of voltage magnitude samples, each tagged with the phase it belongs to (A, B or C). It declares a sag on a phase once a programmed number of back-to-back samples on that phase fall below a programmed threshold. A single sample at or above the threshold ends the run and clears the sag on that phase. Samples on one phase never disturb the run kept for another phase.

Each phase has an enable bit that lets its sag raise a shared, level-sensitive interrupt. A separate enable routes the sag indication of any phase to a dedicated output pin. This routing does not depend on the interrupt enables. The threshold, the run length and the enables sit in small configuration registers. Each group has its own write strobe, so the reset values stay in force until a group is written.

Top module: `sag_watch`

## Requirements
- R1: After reset, all three sag flags, the interrupt and the pin are 0, and the run length is 80, so the 80th consecutive low sample on a phase sets its flag and the 79th does not.
- R2: A sample counts as low when its magnitude is strictly less than the threshold. A phase's flag (sag_flag bit 0 = A, 1 = B, 2 = C; tag 0 = A, 1 = B, 2 = C) becomes 1 in the cycle after the low sample that brings that phase's run of consecutive low samples up to the run length.
- R3: A sample on a phase whose magnitude is at or above the threshold clears that phase's run and its flag in the cycle after that sample.
- R4: The run counter saturates at the run length and does not wrap. With run length 255, the flag stays 1 through 300 consecutive low samples.
- R5: A run length of 0 behaves as 1, so a single low sample sets the flag.
- R6: A sample updates only the run and flag of the phase named by its tag.
- R7: sag_irq is 1 exactly when some phase has both its flag and its interrupt enable (irq_en bit 0 = A, 1 = B, 2 = C) set. It is a level and stays 1 as long as that holds.
- R8: sag_pin is 1 exactly when the pin enable is 1 and any flag is 1, whatever the interrupt enables are.
- R9: A sample with tag 3, or a cycle with smp_valid low, leaves every flag unchanged.
- R10: A configuration write takes effect for samples from the next cycle on. The threshold resets to 0, and the interrupt enables and the pin enable reset to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| smp_valid | input | 1 | Sample strobe |
| smp_phase | input | 2 | Phase tag of the sample (0 = A, 1 = B, 2 = C, 3 = none) |
| smp_mag | input | SAMP_W | Sample magnitude |
| cfg_thr_we | input | 1 | Write strobe for the threshold |
| cfg_thr | input | SAMP_W | Threshold value to write |
| cfg_len_we | input | 1 | Write strobe for the run length |
| cfg_len | input | CNT_W | Run length value to write |
| cfg_ctl_we | input | 1 | Write strobe for the interrupt enables and the pin enable |
| cfg_irq_en | input | 3 | Per-phase interrupt enables to write |
| cfg_pin_en | input | 1 | Pin enable to write |
| sag_flag | output | 3 | Per-phase sag status |
| sag_irq | output | 1 | Masked interrupt level |
| sag_pin | output | 1 | Dedicated sag output pin |

## Verification
The bench builds the block with its default parameters: 16-bit samples, an 8-bit run counter and a reset run length of 80. With these values the reset run length can be checked by sending 79 and then 80 low samples. The full-scale run length of 255 is also in reach, and runs of 300 samples go past the point where an unsaturated 8-bit counter would wrap. The scenarios cover the equal-to-threshold boundary, the zero run length and interleaved phases. They also check the interrupt and pin gating against the same flag pattern under different enables.

// File: rtl/sag_pkg.sv
// Package: shared constants and types for the sag detector.
// Assumes exactly three phases, encoded on a 2-bit tag.
package sag_pkg;
    localparam int NUM_PH = 3;
    localparam int TAG_W  = 2;

    typedef enum logic [TAG_W-1:0] {
        PH_A    = 2'd0,
        PH_B    = 2'd1,
        PH_C    = 2'd2,
        PH_NONE = 2'd3
    } phase_e;
endpackage

// File: rtl/sag_cfg_regs.sv
// Module: configuration register bank for the sag detector.
// Holds threshold, run length, interrupt enables and pin enable.
// Each group has its own write strobe. Values apply from the cycle after the write.
module sag_cfg_regs #(
    parameter int SAMP_W  = 16,
    parameter int CNT_W   = 8,
    parameter int NPH     = 3,
    parameter int LEN_RST = 80
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              thr_we,
    input  logic [SAMP_W-1:0] thr_in,
    input  logic              len_we,
    input  logic [CNT_W-1:0]  len_in,
    input  logic              ctl_we,
    input  logic [NPH-1:0]    irq_en_in,
    input  logic              pin_en_in,
    output logic [SAMP_W-1:0] thr_q,
    output logic [CNT_W-1:0]  len_q,
    output logic [NPH-1:0]    irq_en_q,
    output logic              pin_en_q
);
    localparam logic [CNT_W-1:0] LEN_INIT = CNT_W'(LEN_RST);

    // Threshold register; resets to 0.
    always_ff @(posedge clk) begin
        if (!rst_n)      thr_q <= '0;
        else if (thr_we) thr_q <= thr_in;
    end

    // Run length register; resets to LEN_RST.
    always_ff @(posedge clk) begin
        if (!rst_n)      len_q <= LEN_INIT;
        else if (len_we) len_q <= len_in;
    end

    // Interrupt enables and pin enable; all reset to 0.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irq_en_q <= '0;
            pin_en_q <= 1'b0;
        end else if (ctl_we) begin
            irq_en_q <= irq_en_in;
            pin_en_q <= pin_en_in;
        end
    end
endmodule

// File: rtl/sag_phase_track.sv
// Module: per-phase run counter and sag flag.
// Counts consecutive low samples addressed to this phase. The count saturates
// at the effective run length (a run length of 0 counts as 1). The flag is set
// while the count has reached that length. A high sample clears count and flag.
// Assumes 'hit' is already qualified by the sample strobe and the phase tag.
module sag_phase_track #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             hit,
    input  logic             low,
    input  logic [CNT_W-1:0] run_len,
    output logic             flag
);
    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] eff_len;
    logic [CNT_W-1:0] cnt_nxt;

    // Effective run length: zero is promoted to one.
    always_comb eff_len = (run_len == '0) ? CNT_W'(1) : run_len;

    // Next count on a low sample: add one, but never beyond the effective length.
    always_comb cnt_nxt = (cnt_q >= eff_len) ? eff_len : cnt_q + CNT_W'(1);

    // Counter and flag update on samples addressed to this phase.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
            flag  <= 1'b0;
        end else if (hit) begin
            if (low) begin
                cnt_q <= cnt_nxt;
                flag  <= (cnt_nxt >= eff_len);
            end else begin
                cnt_q <= '0;
                flag  <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/sag_alert_merge.sv
// Module: combines the per-phase flags into the interrupt and the pin.
// The interrupt is the OR of the enabled flags (a level signal).
// The pin follows any flag while the pin enable is set, and ignores the interrupt enables.
module sag_alert_merge #(
    parameter int NPH = 3
) (
    input  logic [NPH-1:0] flags,
    input  logic [NPH-1:0] irq_en,
    input  logic           pin_en,
    output logic           irq,
    output logic           pin
);
    // Interrupt: any flag whose phase enable is set.
    always_comb irq = |(flags & irq_en);

    // Pin: any flag, gated only by the pin enable.
    always_comb pin = pin_en & (|flags);
endmodule

// File: rtl/sag_watch.sv
// Module: three-phase voltage sag detector (top).
// Decodes each sample's phase tag and compares the sample against the threshold once.
// Feeds one tracker per phase and merges the flags into interrupt and pin outputs.
// Assumes at most one sample per cycle. Tag 3 addresses no phase.
module sag_watch #(
    parameter int SAMP_W  = 16,
    parameter int CNT_W   = 8,
    parameter int LEN_RST = 80
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              smp_valid,
    input  logic [1:0]        smp_phase,
    input  logic [SAMP_W-1:0] smp_mag,
    input  logic              cfg_thr_we,
    input  logic [SAMP_W-1:0] cfg_thr,
    input  logic              cfg_len_we,
    input  logic [CNT_W-1:0]  cfg_len,
    input  logic              cfg_ctl_we,
    input  logic [2:0]        cfg_irq_en,
    input  logic              cfg_pin_en,
    output logic [2:0]        sag_flag,
    output logic              sag_irq,
    output logic              sag_pin
);
    import sag_pkg::*;

    logic [SAMP_W-1:0] thr_q;
    logic [CNT_W-1:0]  len_q;
    logic [NUM_PH-1:0] irq_en_q;
    logic              pin_en_q;
    logic              smp_low;
    logic [NUM_PH-1:0] ph_hit;

    sag_cfg_regs #(
        .SAMP_W (SAMP_W),
        .CNT_W  (CNT_W),
        .NPH    (NUM_PH),
        .LEN_RST(LEN_RST)
    ) u_cfg (
        .clk      (clk),
        .rst_n    (rst_n),
        .thr_we   (cfg_thr_we),
        .thr_in   (cfg_thr),
        .len_we   (cfg_len_we),
        .len_in   (cfg_len),
        .ctl_we   (cfg_ctl_we),
        .irq_en_in(cfg_irq_en),
        .pin_en_in(cfg_pin_en),
        .thr_q    (thr_q),
        .len_q    (len_q),
        .irq_en_q (irq_en_q),
        .pin_en_q (pin_en_q)
    );

    // Single shared threshold comparison; strictly below counts as low.
    always_comb smp_low = (smp_mag < thr_q);

    // One tracker per phase, selected by the decoded tag.
    for (genvar p = 0; p < NUM_PH; p++) begin : g_ph
        always_comb ph_hit[p] = smp_valid && (smp_phase == TAG_W'(p));

        sag_phase_track #(
            .CNT_W(CNT_W)
        ) u_trk (
            .clk    (clk),
            .rst_n  (rst_n),
            .hit    (ph_hit[p]),
            .low    (smp_low),
            .run_len(len_q),
            .flag   (sag_flag[p])
        );
    end

    sag_alert_merge #(
        .NPH(NUM_PH)
    ) u_merge (
        .flags (sag_flag),
        .irq_en(irq_en_q),
        .pin_en(pin_en_q),
        .irq   (sag_irq),
        .pin   (sag_pin)
    );
endmodule

// File: rtl/sag_watch_chk.sv
// Module: assertion checker for sag_watch, bound to every instance.
// Relates sample inputs, configuration state and outputs across cycles.
module sag_watch_chk #(
    parameter int SAMP_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              smp_valid,
    input logic [1:0]        smp_phase,
    input logic [SAMP_W-1:0] smp_mag,
    input logic [SAMP_W-1:0] thr_q,
    input logic [2:0]        irq_en_q,
    input logic              pin_en_q,
    input logic [2:0]        sag_flag,
    input logic              sag_irq,
    input logic              sag_pin
);
    for (genvar i = 0; i < 3; i++) begin : g_chk
        // R2: a flag only rises after a low sample on its own phase.
        assert_rise_needs_low_R2: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(sag_flag[i]) |-> $past(smp_valid && smp_phase == 2'(i) && smp_mag < thr_q));

        // R3: a sample at or above the threshold clears that phase's flag.
        assert_high_clears_R3: assert property (@(posedge clk) disable iff (!rst_n)
            (smp_valid && smp_phase == 2'(i) && smp_mag >= thr_q) |=> !sag_flag[i]);
    end

    // R9: no valid sample, or a tag-3 sample, leaves the flags alone.
    assert_idle_stable_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!smp_valid || smp_phase == 2'd3) |=> $stable(sag_flag));

    // R6: one sample changes at most one flag.
    assert_one_phase_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(sag_flag ^ $past(sag_flag)));

    // R7: interrupt only with a flag present, and never without an enabled flag.
    assert_irq_has_flag_R7: assert property (@(posedge clk) disable iff (!rst_n)
        sag_irq |-> (sag_flag != 3'b000));
    assert_irq_needs_en_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ((sag_flag & irq_en_q) == 3'b000) |-> !sag_irq);

    // R8: the pin needs its enable and some flag.
    assert_pin_gated_R8: assert property (@(posedge clk) disable iff (!rst_n)
        sag_pin |-> (pin_en_q && sag_flag != 3'b000));
endmodule

bind sag_watch sag_watch_chk #(.SAMP_W(SAMP_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .smp_valid(smp_valid),
    .smp_phase(smp_phase),
    .smp_mag  (smp_mag),
    .thr_q    (thr_q),
    .irq_en_q (irq_en_q),
    .pin_en_q (pin_en_q),
    .sag_flag (sag_flag),
    .sag_irq  (sag_irq),
    .sag_pin  (sag_pin)
);

// File: tb/sag_watch_bench.sv
`timescale 1ns/1ps
// Bench: directed scenarios, one task each, checking at the ports.
module sag_watch_bench;
    localparam int SAMP_W = 16;
    localparam int CNT_W  = 8;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              smp_valid = 1'b0;
    logic [1:0]        smp_phase = 2'd0;
    logic [SAMP_W-1:0] smp_mag = '0;
    logic              cfg_thr_we = 1'b0;
    logic [SAMP_W-1:0] cfg_thr = '0;
    logic              cfg_len_we = 1'b0;
    logic [CNT_W-1:0]  cfg_len = '0;
    logic              cfg_ctl_we = 1'b0;
    logic [2:0]        cfg_irq_en = '0;
    logic              cfg_pin_en = 1'b0;
    logic [2:0]        sag_flag;
    logic              sag_irq;
    logic              sag_pin;

    int n_chk = 0;
    int n_err = 0;
    bit done  = 1'b0;

    always #2.5 clk = ~clk;

    sag_watch #(.SAMP_W(SAMP_W), .CNT_W(CNT_W), .LEN_RST(80)) u_sag_watch (
        .clk(clk), .rst_n(rst_n),
        .smp_valid(smp_valid), .smp_phase(smp_phase), .smp_mag(smp_mag),
        .cfg_thr_we(cfg_thr_we), .cfg_thr(cfg_thr),
        .cfg_len_we(cfg_len_we), .cfg_len(cfg_len),
        .cfg_ctl_we(cfg_ctl_we), .cfg_irq_en(cfg_irq_en), .cfg_pin_en(cfg_pin_en),
        .sag_flag(sag_flag), .sag_irq(sag_irq), .sag_pin(sag_pin)
    );

    task automatic check(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_err++;
            $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // One sample, driven on a falling edge; outputs settle by the next falling edge.
    task automatic send(input logic v, input logic [1:0] ph, input int mag);
        @(negedge clk);
        smp_valid = v; smp_phase = ph; smp_mag = SAMP_W'(mag);
        @(negedge clk);
        smp_valid = 1'b0;
    endtask

    task automatic send_run(input logic [1:0] ph, input int mag, input int n);
        for (int k = 0; k < n; k++) send(1'b1, ph, mag);
    endtask

    task automatic set_thr(input int t);
        @(negedge clk); cfg_thr_we = 1'b1; cfg_thr = SAMP_W'(t);
        @(negedge clk); cfg_thr_we = 1'b0;
    endtask

    task automatic set_len(input int l);
        @(negedge clk); cfg_len_we = 1'b1; cfg_len = CNT_W'(l);
        @(negedge clk); cfg_len_we = 1'b0;
    endtask

    task automatic set_ctl(input logic [2:0] en, input logic pe);
        @(negedge clk); cfg_ctl_we = 1'b1; cfg_irq_en = en; cfg_pin_en = pe;
        @(negedge clk); cfg_ctl_we = 1'b0;
    endtask

    task automatic clear_all();
        send(1'b1, 2'd0, 60000); send(1'b1, 2'd1, 60000); send(1'b1, 2'd2, 60000);
    endtask

    task automatic t_reset();
        check("R1 flags after reset", int'(sag_flag), 0);
        check("R1 irq after reset", int'(sag_irq), 0);
        check("R1 pin after reset", int'(sag_pin), 0);
        send(1'b1, 2'd0, 0);   // threshold resets to 0: nothing is low
        check("R10 zero threshold at reset", int'(sag_flag), 0);
    endtask

    task automatic t_default_len();
        set_thr(1000);
        send_run(2'd0, 999, 79);
        check("R1 79 low samples", int'(sag_flag[0]), 0);
        send(1'b1, 2'd0, 999);
        check("R1 R2 80th low sample", int'(sag_flag[0]), 1);
        check("R10 irq enables reset to 0", int'(sag_irq), 0);
        check("R10 pin enable resets to 0", int'(sag_pin), 0);
    endtask

    task automatic t_high_clears();
        send(1'b1, 2'd0, 1000);  // equal to threshold: not low
        check("R3 equal sample clears flag", int'(sag_flag[0]), 0);
        send(1'b1, 2'd0, 10);
        check("R3 run restarted", int'(sag_flag[0]), 0);
    endtask

    task automatic t_len_zero();
        set_len(0);
        send(1'b1, 2'd1, 5);
        check("R5 length 0 acts as 1", int'(sag_flag), 3'b010);
        clear_all();
    endtask

    task automatic t_indep();
        set_len(3);
        send(1'b1, 2'd0, 1);
        send(1'b1, 2'd1, 2000);
        send(1'b1, 2'd0, 1);
        send(1'b1, 2'd2, 1);
        send(1'b1, 2'd0, 1);
        check("R6 only A reaches length", int'(sag_flag), 3'b001);
        send(1'b1, 2'd2, 1);
        send(1'b1, 2'd2, 1);
        check("R6 C reaches length, A kept", int'(sag_flag), 3'b101);
    endtask

    task automatic t_irq();
        set_ctl(3'b010, 1'b0);
        check("R7 enable on unflagged phase", int'(sag_irq), 0);
        set_ctl(3'b100, 1'b0);
        check("R7 enable on flagged C", int'(sag_irq), 1);
        repeat (5) @(negedge clk);
        check("R7 irq holds as level", int'(sag_irq), 1);
        send(1'b1, 2'd2, 5000);
        check("R7 irq drops with C flag", int'(sag_irq), 0);
    endtask

    task automatic t_pin();
        check("R8 pin disabled", int'(sag_pin), 0);
        set_ctl(3'b000, 1'b1);
        check("R8 pin with A flag, no irq enables", int'(sag_pin), 1);
        check("R7 irq off with no enables", int'(sag_irq), 0);
        clear_all();
        check("R8 pin drops with no flags", int'(sag_pin), 0);
    endtask

    task automatic t_ignore();
        set_len(1);
        send(1'b1, 2'd3, 1);
        check("R9 tag 3 low sample", int'(sag_flag), 0);
        send(1'b0, 2'd1, 1);
        check("R9 invalid low sample", int'(sag_flag), 0);
        send(1'b1, 2'd1, 1);
        check("R9 setup flag B", int'(sag_flag), 3'b010);
        send(1'b1, 2'd3, 5000);
        send(1'b0, 2'd1, 5000);
        check("R9 tag 3 / invalid high ignored", int'(sag_flag), 3'b010);
        clear_all();
    endtask

    task automatic t_sat();
        set_len(255);
        send_run(2'd2, 3, 254);
        check("R4 254 of 255", int'(sag_flag[2]), 0);
        send(1'b1, 2'd2, 3);
        check("R4 255th sample", int'(sag_flag[2]), 1);
        send_run(2'd2, 3, 2);
        check("R4 past 256 samples", int'(sag_flag[2]), 1);
        send_run(2'd2, 3, 43);
        check("R4 300 samples", int'(sag_flag[2]), 1);
        clear_all();
    endtask

    task automatic t_cfg_timing();
        set_len(1);
        set_thr(500);
        send(1'b1, 2'd0, 600);
        check("R10 raised sample above new threshold", int'(sag_flag[0]), 0);
        send(1'b1, 2'd0, 499);
        check("R10 new threshold applied", int'(sag_flag[0]), 1);
        clear_all();
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_default_len();
        t_high_clears();
        t_len_zero();
        t_indep();
        t_irq();
        t_pin();
        t_ignore();
        t_sat();
        t_cfg_timing();
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        #(5.0 * 200000);
        if (!done) begin
            n_chk++;
            n_err++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end
endmodule